// File: doc/BRIEF.md
# Active-Priority Tracker with End-of-Interrupt

This block holds the active-priority state of one processor's interrupt interface. That state is one bit vector for each of three interrupt groups: group 0, secure group 1 and non-secure group 1. Acknowledge logic sets a bit when it accepts an interrupt. The block then reports the running priority, which is the most urgent priority still active across all three groups.

Software ends an interrupt by writing its identifier through one of two end-of-interrupt registers. The block works out which group that write targets and which group owns the most urgent active bit. It drops the priority only when these two groups match. When split mode is off for the requester's level, it also issues a deactivate request for the written identifier. Permission checks on separate deactivate writes and the distributor state are handled elsewhere.

Top module: `apr_eoi_tracker`

## Requirements
- R1: A set request with group code `set_grp` (0 = group 0, 1 = secure group 1, 2 = non-secure group 1, 3 = no effect) and priority `p` sets bit index `p>>1` of that group's vector. The vector is split into 32-bit words, so the bit is bit `(p>>1)%32` of word `(p>>1)/32`. The change is visible on `run_prio` from the next clock edge.
- R2: The raw running priority is 0xFF when no bit is set in any group. Otherwise it is twice the lowest set bit index over all three groups.
- R3: An end-of-interrupt takes its identifier from the low 24 bits of `eoi_data`. With `eoi_sel`=0 it targets group 0. With `eoi_sel`=1 it targets secure group 1 when `eoi_sec`=1, and non-secure group 1 otherwise.
- R4: An end-of-interrupt whose identifier is at least `NUM_INTS` is ignored: no drop, no deactivate, and no change to the vectors. This covers the special identifiers 1020 to 1023.
- R5: The owning group is found by scanning the words from word 0 upward, comparing trailing-zero counts within each word. Non-secure group 1 owns the word only if its count is strictly below both other counts. Otherwise secure group 1 owns it if its count is below group 0's. Otherwise group 0 owns it if its word is nonzero. If none of these holds, the scan moves to the next word.
- R6: An end-of-interrupt is ignored when no active bit is set anywhere, or when the owning group differs from the targeted group.
- R7: An accepted end-of-interrupt clears only the lowest set bit of the first nonzero word of the targeted group. One cycle later `drop_vld` pulses, with `drop_grp` carrying the group code.
- R8: An accepted end-of-interrupt raises `deact_vld` in the same cycle as `drop_vld`, with `deact_id` holding the identifier, unless split mode is on. Split mode comes from `split_top` when `eoi_top`=1, from `split_s` when `eoi_sec`=1, and from `split_ns` otherwise.
- R9: While `ns_view`=1, `run_prio` shows the non-secure view of the raw running priority. A raw value with bit 7 set, including the idle value 0xFF, reads as 0. Any other raw value reads as `(raw<<1)&0xFF`.
- R10: A set request and an accepted end-of-interrupt in the same cycle both take effect. The drop removes the lowest bit of the state held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_vld | input | 1 | Activate request from acknowledge logic |
| set_grp | input | 2 | Group code of the activated interrupt |
| set_prio | input | 8 | Group priority of the activated interrupt |
| eoi_vld | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 32 | Written data; identifier in the low 24 bits |
| eoi_sel | input | 1 | 0 = group-0 register, 1 = group-1 register |
| eoi_sec | input | 1 | Requester is in the secure state |
| eoi_top | input | 1 | Requester is at the highest privilege level |
| split_top | input | 1 | Split mode for the highest level |
| split_s | input | 1 | Split mode, secure bank |
| split_ns | input | 1 | Split mode, non-secure bank |
| ns_view | input | 1 | Present the non-secure view of the running priority |
| run_prio | output | 8 | Running priority |
| drop_vld | output | 1 | Priority-drop event |
| drop_grp | output | 2 | Group whose priority was dropped |
| deact_vld | output | 1 | Deactivate request |
| deact_id | output | 24 | Identifier to deactivate |

## Verification
A corrupted vector bit shows up on `run_prio` one clock after the faulty update. Later it also appears as a missing or extra `drop_vld` on the next end-of-interrupt that targets that group. An ownership decision that goes the wrong way at a tie suppresses the drop of the correct group and allows the drop of the wrong one in the same cycle. For that reason, the tests put equal trailing-zero counts into two groups and end each group in turn. Clearing the wrong bit stays hidden until that group's next end-of-interrupt, so the tests place two bits in one word and two bits in different words.

// File: rtl/apr_eoi_tracker.sv
`timescale 1ns/1ps
module apr_eoi_tracker #(
  parameter int WORDS    = 4,
  parameter int WBITS    = 32,
  parameter int ID_W     = 24,
  parameter int DATA_W   = 32,
  parameter int NUM_INTS = 960
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          set_vld,
  input  logic [1:0]                    set_grp,
  input  logic [$clog2(WORDS*WBITS):0]  set_prio,
  input  logic                          eoi_vld,
  input  logic [DATA_W-1:0]             eoi_data,
  input  logic                          eoi_sel,
  input  logic                          eoi_sec,
  input  logic                          eoi_top,
  input  logic                          split_top,
  input  logic                          split_s,
  input  logic                          split_ns,
  input  logic                          ns_view,
  output logic [$clog2(WORDS*WBITS):0]  run_prio,
  output logic                          drop_vld,
  output logic [1:0]                    drop_grp,
  output logic                          deact_vld,
  output logic [ID_W-1:0]               deact_id
);
  localparam int IDXW = $clog2(WORDS*WBITS);
  localparam int PW   = IDXW + 1;
  localparam int BIDX = $clog2(WBITS);
  localparam int CTZW = BIDX + 1;

  function automatic logic [CTZW-1:0] ctz(input logic [WBITS-1:0] w);
    ctz = CTZW'(WBITS);
    for (int b = WBITS-1; b >= 0; b--)
      if (w[b]) ctz = CTZW'(b);
  endfunction

  logic [WBITS-1:0] apr [3][WORDS];

  wire [ID_W-1:0] eid  = eoi_data[ID_W-1:0];
  wire            unused_bits = ^{eoi_data[DATA_W-1:ID_W], set_prio[0]};
  wire [1:0]      tgt  = !eoi_sel ? 2'd0 : (eoi_sec ? 2'd1 : 2'd2);
  wire            id_ok = eid < ID_W'(NUM_INTS);
  wire            split = eoi_top ? split_top : (eoi_sec ? split_s : split_ns);

  logic [1:0]     hg;
  logic           hg_found;
  logic [CTZW-1:0] c0, c1, c2;

  always_comb begin
    hg = 2'd3;
    hg_found = 1'b0;
    c0 = '0; c1 = '0; c2 = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (!hg_found) begin
        c0 = ctz(apr[0][w]);
        c1 = ctz(apr[1][w]);
        c2 = ctz(apr[2][w]);
        if (c2 < c0 && c2 < c1) begin
          hg = 2'd2; hg_found = 1'b1;
        end else if (c1 < c0) begin
          hg = 2'd1; hg_found = 1'b1;
        end else if (c0 < CTZW'(WBITS)) begin
          hg = 2'd0; hg_found = 1'b1;
        end
      end
    end
  end

  wire accept = eoi_vld && id_ok && hg_found && (hg == tgt);

  logic [WBITS-1:0] clr [WORDS];
  logic             clr_seen;
  logic [WBITS-1:0] tw;

  always_comb begin
    clr_seen = 1'b0;
    tw = '0;
    for (int w = 0; w < WORDS; w++) begin
      clr[w] = '0;
      tw = apr[tgt][w];
      if (!clr_seen && tw != '0) begin
        clr[w]   = tw & (~tw + 1'b1);
        clr_seen = 1'b1;
      end
    end
  end

  wire [IDXW-1:0] set_idx = set_prio[PW-1:1];

  generate
    for (genvar g = 0; g < 3; g++) begin : g_grp
      for (genvar w = 0; w < WORDS; w++) begin : g_word
        wire hit_set = set_vld && set_grp == 2'(g) &&
                       set_idx[IDXW-1:BIDX] == (IDXW-BIDX)'(w);
        wire [WBITS-1:0] smask = hit_set ? (WBITS'(1) << set_idx[BIDX-1:0]) : '0;
        wire [WBITS-1:0] cmask = (accept && tgt == 2'(g)) ? clr[w] : '0;
        always_ff @(posedge clk) begin
          if (!rst_n) apr[g][w] <= '0;
          else        apr[g][w] <= (apr[g][w] & ~cmask) | smask;
        end
      end
    end
  endgenerate

  logic [IDXW-1:0] low_idx;
  logic            any_act;
  logic [WBITS-1:0] orw;

  always_comb begin
    low_idx = '0;
    any_act = 1'b0;
    orw = '0;
    for (int w = WORDS-1; w >= 0; w--) begin
      orw = apr[0][w] | apr[1][w] | apr[2][w];
      for (int b = WBITS-1; b >= 0; b--)
        if (orw[b]) begin
          low_idx = IDXW'(w*WBITS + b);
          any_act = 1'b1;
        end
    end
  end

  wire [PW-1:0] raw_prio = any_act ? {low_idx, 1'b0} : {PW{1'b1}};

  assign run_prio = !ns_view ? raw_prio :
                    raw_prio[PW-1] ? '0 : {raw_prio[PW-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_vld  <= 1'b0;
      drop_grp  <= 2'd0;
      deact_vld <= 1'b0;
      deact_id  <= '0;
    end else begin
      drop_vld  <= accept;
      drop_grp  <= tgt;
      deact_vld <= accept && !split;
      deact_id  <= eid;
    end
  end
endmodule

// File: rtl/apr_eoi_tracker_chk.sv
`timescale 1ns/1ps
module apr_eoi_tracker_chk #(
  parameter int ID_W     = 24,
  parameter int DATA_W   = 32,
  parameter int PW       = 8,
  parameter int NUM_INTS = 960
) (
  input logic              clk,
  input logic              rst_n,
  input logic              set_vld,
  input logic [1:0]        set_grp,
  input logic [PW-1:0]     set_prio,
  input logic              eoi_vld,
  input logic [DATA_W-1:0] eoi_data,
  input logic              ns_view,
  input logic [PW-1:0]     run_prio,
  input logic              drop_vld,
  input logic              deact_vld,
  input logic [ID_W-1:0]   deact_id
);
  a_r4_big_id_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_vld && eoi_data[ID_W-1:0] >= ID_W'(NUM_INTS)) |=> !drop_vld);

  a_r6_idle_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_vld && !ns_view && run_prio == {PW{1'b1}}) |=> !drop_vld);

  a_r8_deact_with_drop: assert property (@(posedge clk) disable iff (!rst_n)
    deact_vld |-> drop_vld);

  a_r3_id_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    drop_vld |-> deact_id == $past(eoi_data[ID_W-1:0]));

  a_r1_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && !eoi_vld && set_grp != 2'd3) |=>
      (ns_view || run_prio <= {$past(set_prio[PW-1:1]), 1'b0}));
endmodule

bind apr_eoi_tracker apr_eoi_tracker_chk #(
  .ID_W(ID_W), .DATA_W(DATA_W), .PW(PW), .NUM_INTS(NUM_INTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .set_vld(set_vld), .set_grp(set_grp),
  .set_prio(set_prio), .eoi_vld(eoi_vld), .eoi_data(eoi_data),
  .ns_view(ns_view), .run_prio(run_prio), .drop_vld(drop_vld),
  .deact_vld(deact_vld), .deact_id(deact_id)
);

// File: tb/tb_apr_eoi_tracker.sv
`timescale 1ns/1ps
module tb_apr_eoi_tracker;
  localparam int NUM_INTS = 960;
  localparam int NV = 29;

  logic clk = 1'b0, rst_n = 1'b0;
  logic set_vld = 0, eoi_vld = 0, eoi_sel = 0, eoi_sec = 0, eoi_top = 0;
  logic [1:0] set_grp = 0;
  logic [7:0] set_prio = 0;
  logic [31:0] eoi_data = 0;
  logic split_top = 0, split_s = 1, split_ns = 0, ns_view = 0;
  logic [7:0] run_prio;
  logic drop_vld, deact_vld;
  logic [1:0] drop_grp;
  logic [23:0] deact_id;

  int applied = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  apr_eoi_tracker #(.NUM_INTS(NUM_INTS)) dut (
    .clk(clk), .rst_n(rst_n), .set_vld(set_vld), .set_grp(set_grp),
    .set_prio(set_prio), .eoi_vld(eoi_vld), .eoi_data(eoi_data),
    .eoi_sel(eoi_sel), .eoi_sec(eoi_sec), .eoi_top(eoi_top),
    .split_top(split_top), .split_s(split_s), .split_ns(split_ns),
    .ns_view(ns_view), .run_prio(run_prio), .drop_vld(drop_vld),
    .drop_grp(drop_grp), .deact_vld(deact_vld), .deact_id(deact_id));

  // {req, op(1 set, 2 eoi), grp/sel, prio, id, sec, top, exp_prio, exp_drop, exp_dgrp, exp_deact}
  localparam logic [53:0] VEC [NV] = '{
    {4'd1, 2'd1, 2'd0, 8'h40, 24'd0,    1'b0, 1'b0, 8'h40, 1'b0, 2'd0, 1'b0}, // R1 word 1
    {4'd1, 2'd1, 2'd2, 8'h20, 24'd0,    1'b0, 1'b0, 8'h20, 1'b0, 2'd0, 1'b0}, // R1
    {4'd2, 2'd1, 2'd1, 8'h30, 24'd0,    1'b0, 1'b0, 8'h20, 1'b0, 2'd0, 1'b0}, // R2 lowest wins
    {4'd6, 2'd2, 2'd0, 8'h00, 24'd5,    1'b0, 1'b0, 8'h20, 1'b0, 2'd0, 1'b0}, // R6 group mismatch
    {4'd3, 2'd2, 2'd1, 8'h00, 24'd40,   1'b0, 1'b0, 8'h30, 1'b1, 2'd2, 1'b1}, // R3 nonsecure g1
    {4'd8, 2'd2, 2'd1, 8'h00, 24'd41,   1'b1, 1'b0, 8'h40, 1'b1, 2'd1, 1'b0}, // R8 split secure
    {4'd4, 2'd2, 2'd0, 8'h00, 24'd1020, 1'b0, 1'b0, 8'h40, 1'b0, 2'd0, 1'b0}, // R4 special id
    {4'd8, 2'd2, 2'd0, 8'h00, 24'd7,    1'b0, 1'b1, 8'hFF, 1'b1, 2'd0, 1'b1}, // R8 top, no split
    {4'd6, 2'd2, 2'd0, 8'h00, 24'd7,    1'b0, 1'b0, 8'hFF, 1'b0, 2'd0, 1'b0}, // R6 empty
    {4'd1, 2'd1, 2'd0, 8'h0B, 24'd0,    1'b0, 1'b0, 8'h0A, 1'b0, 2'd0, 1'b0}, // R1 odd prio
    {4'd2, 2'd1, 2'd0, 8'h04, 24'd0,    1'b0, 1'b0, 8'h04, 1'b0, 2'd0, 1'b0}, // R2
    {4'd7, 2'd2, 2'd0, 8'h00, 24'd3,    1'b0, 1'b0, 8'h0A, 1'b1, 2'd0, 1'b1}, // R7 one bit only
    {4'd7, 2'd2, 2'd0, 8'h00, 24'd3,    1'b0, 1'b0, 8'hFF, 1'b1, 2'd0, 1'b1}, // R7
    {4'd1, 2'd1, 2'd2, 8'h10, 24'd0,    1'b0, 1'b0, 8'h10, 1'b0, 2'd0, 1'b0}, // R1
    {4'd1, 2'd1, 2'd1, 8'h10, 24'd0,    1'b0, 1'b0, 8'h10, 1'b0, 2'd0, 1'b0}, // R1
    {4'd5, 2'd2, 2'd1, 8'h00, 24'd9,    1'b0, 1'b0, 8'h10, 1'b0, 2'd0, 1'b0}, // R5 ns tie loses
    {4'd5, 2'd2, 2'd1, 8'h00, 24'd9,    1'b1, 1'b0, 8'h10, 1'b1, 2'd1, 1'b0}, // R5
    {4'd5, 2'd2, 2'd1, 8'h00, 24'd9,    1'b0, 1'b0, 8'hFF, 1'b1, 2'd2, 1'b1}, // R5
    {4'd1, 2'd1, 2'd0, 8'h06, 24'd0,    1'b0, 1'b0, 8'h06, 1'b0, 2'd0, 1'b0}, // R1
    {4'd1, 2'd1, 2'd1, 8'h06, 24'd0,    1'b0, 1'b0, 8'h06, 1'b0, 2'd0, 1'b0}, // R1
    {4'd5, 2'd2, 2'd1, 8'h00, 24'd2,    1'b1, 1'b0, 8'h06, 1'b0, 2'd0, 1'b0}, // R5 g0 tie wins
    {4'd5, 2'd2, 2'd0, 8'h00, 24'd2,    1'b0, 1'b0, 8'h06, 1'b1, 2'd0, 1'b1}, // R5
    {4'd5, 2'd2, 2'd1, 8'h00, 24'd2,    1'b1, 1'b0, 8'hFF, 1'b1, 2'd1, 1'b0}, // R5
    {4'd2, 2'd1, 2'd2, 8'hFE, 24'd0,    1'b0, 1'b0, 8'hFE, 1'b0, 2'd0, 1'b0}, // R2 top bit
    {4'd7, 2'd2, 2'd1, 8'h00, 24'd900,  1'b0, 1'b0, 8'hFF, 1'b1, 2'd2, 1'b1}, // R7 last word
    {4'd1, 2'd1, 2'd0, 8'h42, 24'd0,    1'b0, 1'b0, 8'h42, 1'b0, 2'd0, 1'b0}, // R1
    {4'd1, 2'd1, 2'd0, 8'h40, 24'd0,    1'b0, 1'b0, 8'h40, 1'b0, 2'd0, 1'b0}, // R1
    {4'd7, 2'd2, 2'd0, 8'h00, 24'd1,    1'b0, 1'b0, 8'h42, 1'b1, 2'd0, 1'b1}, // R7
    {4'd7, 2'd2, 2'd0, 8'h00, 24'd1,    1'b0, 1'b0, 8'hFF, 1'b1, 2'd0, 1'b1}  // R7
  };

  task automatic step(input bit sv, input logic [1:0] sg, input logic [7:0] sp,
                      input bit ev, input logic [31:0] ed, input bit es,
                      input bit ec, input bit et);
    set_vld = sv; set_grp = sg; set_prio = sp;
    eoi_vld = ev; eoi_data = ed; eoi_sel = es; eoi_sec = ec; eoi_top = et;
    @(posedge clk);
    @(negedge clk);
    set_vld = 0; eoi_vld = 0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset", {20'd0, run_prio, drop_vld, drop_grp, deact_vld}, {20'd0, 8'hFF, 4'b0});
    rst_n = 1;
    @(negedge clk);
    check("R2 idle", {24'd0, run_prio}, 32'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [53:0] v;
      logic [11:0] exp, act;
      v = VEC[i];
      step(v[49:48] == 2'd1, v[47:46], v[45:38], v[49:48] == 2'd2,
           {8'h00, v[37:14]}, v[46], v[13], v[12]);
      exp = {v[11:4], v[3], v[3] ? v[2:1] : 2'd0, v[0]};
      act = {run_prio, drop_vld, drop_vld ? drop_grp : 2'd0, deact_vld};
      applied++;
      if (act !== exp) begin
        fails++;
        $display("FAIL R%0d vector %0d: actual %h expected %h", v[53:50], i, act, exp);
      end
    end

    // R4 boundary and R3 upper data bits
    step(1, 2'd0, 8'h02, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 32'(NUM_INTS), 0, 0, 0);
    check("R4 id at limit", {23'd0, run_prio, drop_vld}, {23'd0, 8'h02, 1'b0});
    step(0, 0, 0, 1, {8'hAB, 24'(NUM_INTS - 1)}, 0, 0, 0);
    check("R4 id below limit", {23'd0, run_prio, drop_vld}, {23'd0, 8'hFF, 1'b1});
    check("R3 id low bits", {8'd0, deact_id}, 32'(NUM_INTS - 1));

    // R8 split at top level
    split_top = 1;
    step(1, 2'd0, 8'h02, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 32'd4, 0, 0, 1);
    check("R8 split top", {22'd0, run_prio, drop_vld, deact_vld}, {22'd0, 8'hFF, 2'b10});
    split_top = 0;

    // R10 set and eoi in the same cycle
    step(1, 2'd0, 8'h08, 0, 0, 0, 0, 0);
    step(1, 2'd0, 8'h02, 1, 32'd6, 0, 0, 0);
    check("R10 concurrent", {23'd0, run_prio, drop_vld}, {23'd0, 8'h02, 1'b1});
    step(0, 0, 0, 1, 32'd6, 0, 0, 0);
    check("R10 drain", {24'd0, run_prio}, 32'hFF);

    // R9 non-secure view
    ns_view = 1;
    #1 check("R9 idle view", {24'd0, run_prio}, 32'h00);
    step(1, 2'd0, 8'h90, 0, 0, 0, 0, 0);
    check("R9 upper half", {24'd0, run_prio}, 32'h00);
    step(1, 2'd2, 8'h20, 0, 0, 0, 0, 0);
    check("R9 shifted", {24'd0, run_prio}, 32'h40);
    step(0, 0, 0, 1, 32'd8, 1, 0, 0);
    check("R9 after drop", {23'd0, run_prio, drop_vld}, {23'd0, 8'h00, 1'b1});
    ns_view = 0;
    #1 check("R2 raw", {24'd0, run_prio}, 32'h90);
    step(0, 0, 0, 1, 32'd8, 0, 0, 0);
    check("R7 final", {23'd0, run_prio, drop_vld}, {23'd0, 8'hFF, 1'b1});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end
endmodule